// File: doc/BRIEF.md
# SPI Serial EEPROM Page-Write Engine

This block is the slave side of a small serial EEPROM. It listens on a four-wire SPI link in mode 0 and oversamples the link with the system clock. A byte array, sized by a parameter, holds the stored data. The block decodes five commands: write enable, page write, status write, status read and a sequential data read. The data read exists so that the results of writes can be seen at the pins.

A page write carries an opcode, a 24-bit address and one or more data bytes. The data bytes are gathered in a page buffer. When chip select rises, the frame is judged against four rejection rules:
- the write-enable latch is clear;
- a write cycle is running;
- the frame did not end on a whole byte;
- the page lies in a protected region.

If no rule rejects the frame, the block starts a self-timed cycle. The cycle first erases the addressed bytes to 0x00. It then programs them with the buffered values. Each of the two phases lasts a parameter number of clocks, and the status register shows the block as busy for the whole cycle.

Top module: `eepw_page_writer`

## Requirements
- R1: After reset the status byte reads 0x00 and every array byte reads 0x00 (the erased value).
- R2: Opcode 0x05 returns the status byte MSB first on MISO, repeated for as long as chip select stays low. The status bits are: bit 0 write in progress, bit 1 write-enable latch, bits 3:2 block-protect field, bits 7:4 zero. MISO is 0 while chip select is high.
- R3: Opcode 0x06 sets the write-enable latch when chip select rises exactly 8 bits into the frame.
- R4: An accepted page write (0x02, then a 24-bit address MSB first, then data bytes) leaves each addressed byte equal to its data byte, even where an old bit was 1 and the new bit is 0. The other bytes of the page are unchanged.
- R5: The byte address advances within the page (page size 256). Data past the last byte of the page wraps to byte 0 of the same page.
- R6: A page write is rejected with the array unchanged when the write-enable latch is clear.
- R7: A page write whose chip select rises at a bit count that is not a multiple of 8 is rejected, and it clears the write-enable latch.
- R8: While a write cycle runs, a page write and a write enable are both ignored, and a rejected page write clears the latch.
- R9: Opcode 0x01 followed by one byte loads bits 3:2 into the protect field, but only if the latch is set and the frame is exactly 16 bits; the frame then clears the latch. The protect field is 00 none, 01 top quarter, 10 top half, 11 whole array. A page write into a protected quarter is rejected and clears the latch.
- R10: An accepted write holds write-in-progress for exactly 2 x PHASE_CYCLES clocks. At the end of the cycle the write-enable latch clears.
- R11: Opcode 0x03 followed by a 24-bit address returns bytes from that address, incrementing and wrapping at the end of the array.
- R12: A page write frame with no data byte (exactly 32 bits) is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |

## Verification
The end of a new frame can coincide with a running erase/program cycle. A write enable or a second page write therefore lands at the moment the engine is busy or is clearing its latch. The bench provokes this by sending frames back to back right after an accepted write, while the phase counter is still running. It judges the outcome by the status byte after the cycle ends, and by reading back the page the second frame aimed at.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_PGWR = 8'h02;
    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WREN = 8'h06;

    localparam int BITCNT_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ERASE,
        PH_PROG
    } phase_e;

    typedef struct packed {
        logic [1:0] guard;
        logic       wel;
        logic       wip;
    } stat_t;

    typedef struct packed {
        logic                sel;
        logic                start;
        logic                stop;
        logic                fall;
        logic                byte_done;
        logic [7:0]          byte_val;
        logic [BITCNT_W-1:0] bits;
    } link_t;

    function automatic logic [7:0] stat_byte(stat_t s);
        return {4'b0000, s.guard, s.wel, s.wip};
    endfunction

    function automatic logic region_locked(logic [1:0] guard, logic [1:0] quarter);
        case (guard)
            2'b00:   return 1'b0;
            2'b01:   return quarter == 2'b11;
            2'b10:   return quarter[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/eepw_spi_front.sv
module eepw_spi_front
    import eepw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  sck,
    input  logic  mosi,
    output link_t link
);

    logic [SYNC_STAGES-1:0] cs_q, sck_q, mosi_q;
    logic                   cs_d, sck_d;
    logic [6:0]             sr;
    logic [BITCNT_W-1:0]    bits;
    logic                   byte_done;
    logic [7:0]             byte_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= '1;
            sck_q  <= '0;
            mosi_q <= '0;
            cs_d   <= 1'b1;
            sck_d  <= 1'b0;
        end else begin
            cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
            sck_q  <= {sck_q[SYNC_STAGES-2:0], sck};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
            cs_d   <= cs_q[SYNC_STAGES-1];
            sck_d  <= sck_q[SYNC_STAGES-1];
        end
    end

    logic cs_s, sck_s, mosi_s, sel, rise;
    assign cs_s   = cs_q[SYNC_STAGES-1];
    assign sck_s  = sck_q[SYNC_STAGES-1];
    assign mosi_s = mosi_q[SYNC_STAGES-1];
    assign sel    = !cs_s;
    assign rise   = sel && sck_s && !sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            bits      <= '0;
            byte_done <= 1'b0;
            byte_val  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (cs_d && !cs_s) begin
                bits <= '0;
            end else if (rise) begin
                sr <= {sr[5:0], mosi_s};
                if (bits != '1) bits <= bits + 1'b1;
                if (bits[2:0] == 3'd7) begin
                    byte_val  <= {sr, mosi_s};
                    byte_done <= 1'b1;
                end
            end
        end
    end

    assign link.sel       = sel;
    assign link.start     = cs_d && !cs_s;
    assign link.stop      = !cs_d && cs_s;
    assign link.fall      = sel && !sck_s && sck_d;
    assign link.byte_done = byte_done;
    assign link.byte_val  = byte_val;
    assign link.bits      = bits;

endmodule

// File: rtl/eepw_ctrl.sv
module eepw_ctrl
    import eepw_pkg::*;
#(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 256,
    localparam int ADDR_W    = $clog2(MEM_BYTES),
    localparam int COL_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  link_t             link,
    input  logic              busy,
    input  logic              cyc_done,
    output logic              start_cyc,
    output logic [PAGE_W-1:0] cyc_page,
    input  logic [COL_W-1:0]  buf_idx,
    output logic [7:0]        buf_data,
    output logic              buf_mask,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output stat_t             status,
    output logic              miso_o
);

    localparam logic [BITCNT_W-1:0] B_OPC  = BITCNT_W'(8);
    localparam logic [BITCNT_W-1:0] B_SR   = BITCNT_W'(16);
    localparam logic [BITCNT_W-1:0] B_ADDR = BITCNT_W'(32);
    localparam logic [BITCNT_W-1:0] B_DATA = BITCNT_W'(40);

    logic [7:0]            opcode;
    logic [ADDR_W-1:0]     addr;
    logic [1:0]            guard_pend;
    logic                  wel;
    logic [1:0]            guard;
    logic                  fresh;
    logic [COL_W-1:0]      col;
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic [7:0]            tx;
    logic [ADDR_W-1:0]     rptr;

    logic [ADDR_W-1:0] addr_next;
    logic              on_byte, take_data, pw_ok, at_load;

    assign addr_next = ADDR_W'({addr, link.byte_val});
    assign on_byte   = link.bits[2:0] == 3'd0;
    assign take_data = link.byte_done && opcode == OPC_PGWR && link.bits >= B_DATA
                       && fresh && !busy;
    assign pw_ok     = wel && fresh && !busy && on_byte && link.bits >= B_DATA
                       && !region_locked(guard, addr[ADDR_W-1 -: 2]);

    assign status.guard = guard;
    assign status.wel   = wel;
    assign status.wip   = busy;
    assign cyc_page     = addr[ADDR_W-1:COL_W];
    assign buf_data     = pbuf[buf_idx];
    assign buf_mask     = pmask[buf_idx];

    // command decode and acceptance rules
    always_ff @(posedge clk) begin
        if (rst) begin
            opcode     <= '0;
            addr       <= '0;
            guard_pend <= '0;
            wel        <= 1'b0;
            guard      <= '0;
            fresh      <= 1'b0;
            col        <= '0;
            start_cyc  <= 1'b0;
        end else begin
            start_cyc <= 1'b0;
            if (cyc_done) wel <= 1'b0;
            if (link.start) begin
                opcode <= '0;
                fresh  <= !busy;
            end
            if (link.byte_done) begin
                if (link.bits == B_OPC) begin
                    opcode <= link.byte_val;
                end else if (link.bits <= B_ADDR) begin
                    addr <= addr_next;
                    if (link.bits == B_SR) guard_pend <= link.byte_val[3:2];
                    if (link.bits == B_ADDR) col <= addr_next[COL_W-1:0];
                end else if (take_data) begin
                    col <= col + 1'b1;
                end
            end
            if (link.stop) begin
                case (opcode)
                    OPC_WREN: if (link.bits == B_OPC && !busy) wel <= 1'b1;
                    OPC_PGWR: begin
                        if (pw_ok) start_cyc <= 1'b1;
                        else       wel       <= 1'b0;
                    end
                    OPC_WRSR: begin
                        if (wel && !busy) begin
                            wel <= 1'b0;
                            if (link.bits == B_SR) guard <= guard_pend;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // page buffer and byte-valid mask
    always_ff @(posedge clk) begin
        if (rst) begin
            pmask <= '0;
        end else if (link.start && !busy) begin
            pmask <= '0;
        end else if (take_data) begin
            pmask[col] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take_data) pbuf[col] <= link.byte_val;
    end

    // response shifter, updated on falling SCK
    assign at_load = link.bits[2:0] == 3'd0 && link.bits >= B_OPC;
    assign rd_addr = (link.bits == B_ADDR) ? addr : rptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx   <= '0;
            rptr <= '0;
        end else if (link.start) begin
            tx <= '0;
        end else if (link.fall) begin
            if (at_load) begin
                case (opcode)
                    OPC_RDSR: tx <= stat_byte(status);
                    OPC_READ: begin
                        if (link.bits >= B_ADDR) begin
                            tx   <= rd_data;
                            rptr <= rd_addr + 1'b1;
                        end else begin
                            tx <= '0;
                        end
                    end
                    default: tx <= '0;
                endcase
            end else begin
                tx <= {tx[6:0], 1'b0};
            end
        end
    end

    assign miso_o = link.sel && tx[7];

endmodule

// File: rtl/eepw_store.sv
module eepw_store
    import eepw_pkg::*;
#(
    parameter int MEM_BYTES    = 1024,
    parameter int PAGE_BYTES   = 256,
    parameter int PHASE_CYCLES = 512,
    localparam int ADDR_W      = $clog2(MEM_BYTES),
    localparam int COL_W       = $clog2(PAGE_BYTES),
    localparam int PAGE_W      = ADDR_W - COL_W,
    localparam int TICK_W      = $clog2(PHASE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PAGE_W-1:0] page,
    output logic              busy,
    output logic              cyc_done,
    output logic [COL_W-1:0]  buf_idx,
    input  logic [7:0]        buf_data,
    input  logic              buf_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(PHASE_CYCLES - 1);
    localparam logic [TICK_W-1:0] WALK_END  = TICK_W'(PAGE_BYTES);

    phase_e            ph;
    logic [TICK_W-1:0] tick;
    logic [PAGE_W-1:0] pg;
    logic [7:0]        mem [MEM_BYTES];

    logic              last, walking;
    logic [ADDR_W-1:0] waddr;

    assign last     = tick == LAST_TICK;
    assign walking  = tick < WALK_END;
    assign buf_idx  = tick[COL_W-1:0];
    assign waddr    = {pg, buf_idx};
    assign busy     = ph != PH_IDLE;
    assign cyc_done = ph == PH_PROG && last;
    assign rd_data  = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            tick <= '0;
            pg   <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    tick <= '0;
                    if (start) begin
                        ph <= PH_ERASE;
                        pg <= page;
                    end
                end
                PH_ERASE: begin
                    if (last) begin
                        ph   <= PH_PROG;
                        tick <= '0;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                PH_PROG: begin
                    if (last) begin
                        ph   <= PH_IDLE;
                        tick <= '0;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // one byte per clock: clear in the first phase, load in the second
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
        end else if (busy && walking && buf_mask) begin
            mem[waddr] <= (ph == PH_PROG) ? buf_data : 8'h00;
        end
    end

endmodule

// File: rtl/eepw_page_writer.sv
module eepw_page_writer
    import eepw_pkg::*;
#(
    parameter int MEM_BYTES    = 1024,
    parameter int PAGE_BYTES   = 256,
    parameter int PHASE_CYCLES = 512,
    parameter int SYNC_STAGES  = 2,
    localparam int ADDR_W      = $clog2(MEM_BYTES),
    localparam int COL_W       = $clog2(PAGE_BYTES),
    localparam int PAGE_W      = ADDR_W - COL_W
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);

    link_t             link;
    logic              busy, cyc_done, start_cyc, buf_mask;
    logic [PAGE_W-1:0] cyc_page;
    logic [COL_W-1:0]  buf_idx;
    logic [7:0]        buf_data, rd_data;
    logic [ADDR_W-1:0] rd_addr;
    stat_t             status;

    eepw_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sck  (sck),
        .mosi (mosi),
        .link (link)
    );

    eepw_ctrl #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .link      (link),
        .busy      (busy),
        .cyc_done  (cyc_done),
        .start_cyc (start_cyc),
        .cyc_page  (cyc_page),
        .buf_idx   (buf_idx),
        .buf_data  (buf_data),
        .buf_mask  (buf_mask),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .status    (status),
        .miso_o    (miso)
    );

    eepw_store #(
        .MEM_BYTES   (MEM_BYTES),
        .PAGE_BYTES  (PAGE_BYTES),
        .PHASE_CYCLES(PHASE_CYCLES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .start    (start_cyc),
        .page     (cyc_page),
        .busy     (busy),
        .cyc_done (cyc_done),
        .buf_idx  (buf_idx),
        .buf_data (buf_data),
        .buf_mask (buf_mask),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/eepw_checker.sv
module eepw_checker
    import eepw_pkg::*;
#(
    parameter int PHASE_CYCLES = 512,
    parameter int PAGE_W       = 2,
    localparam int LEN_W       = $clog2(2 * PHASE_CYCLES + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              miso,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [PAGE_W-1:0] page,
    input stat_t             status
);

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(2 * PHASE_CYCLES);

    logic [LEN_W-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst)       busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    // R8: a cycle never starts on top of a running one
    p_start_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R10: busy follows an accepted write at once
    p_busy_follows_start_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R10: both phases together last exactly 2 x PHASE_CYCLES clocks
    p_cycle_length_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_len == FULL_LEN);

    // R10: write-enable latch gone after completion
    p_wel_drop_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !status.wel);

    // R6: no cycle without the latch
    p_start_needs_wel_r6: assert property (@(posedge clk) disable iff (rst)
        start |-> status.wel);

    // R9: never start on a locked page
    p_unlocked_page_r9: assert property (@(posedge clk) disable iff (rst)
        start |-> !region_locked(status.guard, page[PAGE_W-1 -: 2]));

    // R2: quiet output while deselected
    p_quiet_deselected_r2: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

endmodule

bind eepw_page_writer eepw_checker #(
    .PHASE_CYCLES(PHASE_CYCLES),
    .PAGE_W      (PAGE_W)
) i_eepw_checker (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .miso   (miso),
    .start  (start_cyc),
    .busy   (busy),
    .done   (cyc_done),
    .page   (cyc_page),
    .status (status)
);

// File: tb/test_eepw_page_writer.sv
module test_eepw_page_writer;

    localparam int MEM   = 1024;
    localparam int PAGE  = 256;
    localparam int PHASE = 512;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    always #4 clk = ~clk;

    eepw_page_writer #(
        .MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .PHASE_CYCLES(PHASE)
    ) i_eepw_page_writer (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit reported = 0;

    logic [7:0] tx_b [0:15];
    logic [7:0] rx_b [0:15];
    logic [7:0] exp_mem [MEM];
    logic       exp_wel = 0;
    logic [1:0] exp_bp = 0;
    logic [7:0] s;

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input int nbytes, input int extra);
        cs_n = 1'b0;
        wait_n(HALF);
        for (int b = 0; b <= nbytes; b++) begin
            for (int i = 7; i >= 0; i--) begin
                if (b == nbytes && (7 - i) >= extra) break;
                mosi = tx_b[b][i];
                wait_n(HALF);
                if (b < 16) rx_b[b][i] = miso;
                sck = 1'b1;
                wait_n(HALF);
                sck = 1'b0;
            end
        end
        wait_n(HALF);
        cs_n = 1'b1;
        wait_n(4 * HALF);
    endtask

    task automatic rdsr(output logic [7:0] st);
        tx_b[0] = 8'h05; tx_b[1] = 8'h00; tx_b[2] = 8'h00;
        xfer(3, 0);
        st = rx_b[1];
    endtask

    function automatic logic [7:0] exp_status(input logic wip);
        return {4'b0000, exp_bp, exp_wel, wip};
    endfunction

    task automatic wren();
        tx_b[0] = 8'h06;
        xfer(1, 0);
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] st;
        int tries = 0;
        do begin
            rdsr(st);
            tries++;
        end while (st[0] && tries < 40);
        chk(req, st, exp_status(1'b0));
    endtask

    function automatic logic locked(input logic [1:0] bp, input int a);
        logic [1:0] q = 2'((a % MEM) / (MEM / 4));
        case (bp)
            2'b00:   return 0;
            2'b01:   return q == 2'b11;
            2'b10:   return q[1];
            default: return 1;
        endcase
    endfunction

    // data bytes already placed in tx_b[4..]; updates the model
    task automatic page_wr(input int a, input int n, input int extra, input bit busy_now);
        bit ok;
        tx_b[0] = 8'h02;
        tx_b[1] = 8'((a >> 16) & 255);
        tx_b[2] = 8'((a >> 8) & 255);
        tx_b[3] = 8'(a & 255);
        ok = exp_wel && !busy_now && extra == 0 && n >= 1 && !locked(exp_bp, a);
        if (ok) begin
            for (int k = 0; k < n; k++)
                exp_mem[((a % MEM) / PAGE) * PAGE + (((a % PAGE) + k) % PAGE)] = tx_b[4 + k];
        end
        if (!ok && !busy_now) exp_wel = 0;
        xfer(4 + n, extra);
    endtask

    task automatic wrsr(input logic [7:0] v);
        tx_b[0] = 8'h01; tx_b[1] = v;
        if (exp_wel) begin
            exp_bp = v[3:2];
            exp_wel = 0;
        end
        xfer(2, 0);
    endtask

    task automatic read_check(input int a, input int len, input string req);
        tx_b[0] = 8'h03;
        tx_b[1] = 8'((a >> 16) & 255);
        tx_b[2] = 8'((a >> 8) & 255);
        tx_b[3] = 8'(a & 255);
        for (int k = 0; k < len; k++) tx_b[4 + k] = 8'h00;
        xfer(4 + len, 0);
        for (int k = 0; k < len; k++) chk(req, rx_b[4 + k], exp_mem[(a + k) % MEM]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_01a7));
        for (int i = 0; i < MEM; i++) exp_mem[i] = 8'h00;
        wait_n(10);
        rst = 1'b0;
        wait_n(10);

        // R1 reset state, R11 read wraps array end
        rdsr(s);
        chk("R1", s, 8'h00);
        read_check(MEM - 3, 6, "R1/R11");

        // R3 write enable, R2 status layout
        wren(); exp_wel = 1;
        rdsr(s);
        chk("R3", s, 8'h02);

        // R4 accepted write, R10 busy visible with latch held
        tx_b[4] = 8'hA5; tx_b[5] = 8'hFF; tx_b[6] = 8'h3C;
        page_wr(PAGE + 16, 3, 0, 0);
        rdsr(s);
        chk("R10", s, 8'h03);
        exp_wel = 0;
        wait_idle("R10");
        read_check(PAGE + 15, 5, "R4");

        // R4 erase before program: 0xFF becomes 0x0F
        wren(); exp_wel = 1;
        tx_b[4] = 8'h0F;
        page_wr(PAGE + 17, 1, 0, 0);
        exp_wel = 0;
        wait_idle("R4");
        read_check(PAGE + 16, 3, "R4");

        // R6 no latch
        tx_b[4] = 8'h77;
        page_wr(20, 1, 0, 0);
        wait_idle("R6");
        read_check(19, 3, "R6");

        // R7 chip select rises mid-byte
        wren(); exp_wel = 1;
        tx_b[4] = 8'h11; tx_b[5] = 8'h22; tx_b[6] = 8'hE0;
        page_wr(40, 2, 3, 0);
        rdsr(s);
        chk("R7", s, exp_status(1'b0));
        read_check(40, 2, "R7");

        // R12 no data bytes
        wren(); exp_wel = 1;
        page_wr(60, 0, 0, 0);
        rdsr(s);
        chk("R12", s, exp_status(1'b0));
        read_check(60, 1, "R12");

        // R8 second write lands while the cycle runs
        wren(); exp_wel = 1;
        tx_b[4] = 8'h5A;
        page_wr(2 * PAGE + 5, 1, 0, 0);
        tx_b[4] = 8'hC3; tx_b[5] = 8'h3C;
        page_wr(100, 2, 0, 1);
        exp_wel = 0;
        wait_idle("R8");
        read_check(100, 2, "R8");
        read_check(2 * PAGE + 5, 1, "R8");

        // R8 write enable during busy is ignored
        wren(); exp_wel = 1;
        tx_b[4] = 8'h99;
        page_wr(2 * PAGE + 6, 1, 0, 0);
        wren();
        exp_wel = 0;
        wait_idle("R8");
        rdsr(s);
        chk("R8", s, 8'h00);

        // R5 wrap inside the page
        wren(); exp_wel = 1;
        tx_b[4] = 8'h01; tx_b[5] = 8'h02; tx_b[6] = 8'h03; tx_b[7] = 8'h04;
        page_wr(2 * PAGE + PAGE - 2, 4, 0, 0);
        exp_wel = 0;
        wait_idle("R5");
        read_check(2 * PAGE + PAGE - 3, 3, "R5");
        read_check(2 * PAGE, 3, "R5");
        read_check(3 * PAGE, 1, "R5");

        // R9 protect field and its quarters
        wrsr(8'h04);
        rdsr(s);
        chk("R9", s, 8'h00);
        wren(); exp_wel = 1;
        wrsr(8'h04);
        rdsr(s);
        chk("R9", s, 8'h04);
        wren(); exp_wel = 1;
        tx_b[4] = 8'hEE;
        page_wr(3 * PAGE + 1, 1, 0, 0);
        rdsr(s);
        chk("R9", s, 8'h04);
        read_check(3 * PAGE + 1, 1, "R9");
        wren(); exp_wel = 1;
        tx_b[4] = 8'hD1;
        page_wr(2 * PAGE + 9, 1, 0, 0);
        exp_wel = 0;
        wait_idle("R9");
        read_check(2 * PAGE + 9, 1, "R9");
        wren(); exp_wel = 1;
        wrsr(8'h08);
        wren(); exp_wel = 1;
        tx_b[4] = 8'hD2;
        page_wr(2 * PAGE + 10, 1, 0, 0);
        read_check(2 * PAGE + 10, 1, "R9");
        wren(); exp_wel = 1;
        wrsr(8'h0C);
        wren(); exp_wel = 1;
        tx_b[4] = 8'hD3;
        page_wr(7, 1, 0, 0);
        read_check(7, 1, "R9");
        wren(); exp_wel = 1;
        wrsr(8'h00);
        rdsr(s);
        chk("R9", s, 8'h00);

        // random writes, some without the latch
        for (int it = 0; it < 8; it++) begin
            int pg = $urandom_range(0, MEM / PAGE - 1);
            int col = $urandom_range(0, PAGE - 1);
            int n = $urandom_range(1, 8);
            bit en = ($urandom_range(0, 3) != 0);
            if (it == 7) col = PAGE - 3;
            if (en) begin
                wren(); exp_wel = 1;
            end
            for (int k = 0; k < n; k++) tx_b[4 + k] = 8'($urandom);
            page_wr(pg * PAGE + col, n, 0, 0);
            exp_wel = 0;
            wait_idle("R4");
            if (col + n > PAGE) begin
                read_check(pg * PAGE + col, PAGE - col, "R5");
                read_check(pg * PAGE, col + n - PAGE + 1, "R5");
            end else begin
                read_check((pg * PAGE + col + MEM - 1) % MEM, n + 2, "R4");
            end
        end

        report();
        $finish;
    end

endmodule